// File: doc/BRIEF.md
# Table-Based Sine Phase Accumulator

This block produces a stream of signed 8-bit sine samples by phase accumulation. An 8-bit phase register steps forward by a 4-bit frequency word each time a sample is taken, so the output frequency is `freq_word × fs / 256`. With a 4 kHz tick this covers 0 to about 234 Hz in 15.625 Hz steps. Each sample is looked up from the phase as it stood before the step.

Only the non-negative half of the waveform is stored, in a 128-entry ROM. The table is filled at elaboration by a function, so no table literal appears in the source. Phase bits [6:0] select the entry. When the phase is 128 or more, the entry is two's-complemented. A slow-test select takes a sample only once per 100 ticks, which divides every frequency by 100.

The output is a stream with a valid strobe and no ready. The block accepts no back-pressure. A consumer must capture `sample` in the cycle that `sample_valid` is high, and the value then holds until the next strobe. The control pins `tick`, `freq_word` and `slow_sel` are plain levels, sampled on the clock edge.

Top module: `sine_phase_gen`

## Requirements
- R1: On every sample taken, the internal phase grows by `freq_word`, modulo 256.
- R2: For a phase p below 128, the emitted sample equals table entry p, where p is the phase before that sample's step.
- R3: For a phase p of 128 or more, the emitted sample is the two's complement of table entry p−128. The value 0x80 never appears on `sample`.
- R4: Table entry k equals round(127·sin(π·k/128)). This gives entry 0 = 0 and entry 64 = 127, so phase 64 yields 0x7F and phase 192 yields 0x81.
- R5: With `slow_sel` low, every clock with `tick` high takes a sample. The new value appears with `sample_valid` high after that clock edge.
- R6: With `slow_sel` high, only the 100th tick takes a sample, and every 100th tick after it. The count starts at reset and restarts whenever `slow_sel` is low.
- R7: `sample_valid` is high for exactly one clock per sample taken. `sample` does not change while `sample_valid` is low.
- R8: Asynchronous active-low reset clears the phase and the tick count, and drives `sample` to 0 and `sample_valid` to 0. The first sample after reset therefore reads entry 0.
- R9: With `freq_word` = 0, the phase does not move and each strobe repeats the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base sample-rate tick, one clock wide |
| freq_word | input | 4 | Phase increment per sample |
| slow_sel | input | 1 | Take a sample only once per 100 ticks |
| sample | output | 8 | Signed sine sample, two's complement |
| sample_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench targets the following corner cases:

- **Half-wave seam at phases 127/128 and the wrap from 255 to 0.** A design that picks the sign from the wrong bit, or negates off by one, would emit positive values in the second half or a 0x80 code.
- **The exact peak entries.** Phase 64 must give 0x7F and phase 192 must give 0x81; a table built with truncation or a 128-wide angle step would miss them.
- **The slow divider.** It must produce nothing on ticks 1 to 99 and fire on tick 100. It must also restart its count when the slow select drops mid-count; an off-by-one or stale counter would fire early or late.
- **Zero frequency word.** The phase must stay frozen, so every strobe repeats the same sample.

// File: rtl/sine_phase_pkg.sv
package sine_phase_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Rounded half-wave value for entry k of a table of given depth and peak.
  function automatic int half_sine_entry(input int k, input int depth, input int peak);
    real x;
    x = real'(peak) * $sin(PI_R * real'(k) / real'(depth));
    return int'(x);
  endfunction

endpackage

// File: rtl/sine_halfwave_rom.sv
module sine_halfwave_rom
  import sine_phase_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int MAG_W = 7
) (
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PEAK  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int VAL = half_sine_entry(k, DEPTH, PEAK);
    assign tbl[k] = MAG_W'(VAL);
  end

  assign mag = tbl[idx];

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic slow,
  output logic fire
);
  localparam int          CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign fire    = tick & (~slow | at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!slow) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int PHASE_W = 8,
  parameter int STEP_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [STEP_W-1:0]  step,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (advance) begin
      phase <= phase + PHASE_W'(step);
    end
  end
endmodule

// File: rtl/sine_phase_gen.sv
module sine_phase_gen #(
  parameter int PHASE_W  = 8,
  parameter int FREQ_W   = 4,
  parameter int SAMPLE_W = 8,
  parameter int SLOW_DIV = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [FREQ_W-1:0]   freq_word,
  input  logic                slow_sel,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sample_valid
);
  localparam int IDX_W = PHASE_W - 1;
  localparam int MAG_W = SAMPLE_W - 1;

  logic                fire;
  logic [PHASE_W-1:0]  phase_q;
  logic [MAG_W-1:0]    mag;
  logic [SAMPLE_W-1:0] pos_val;
  logic [SAMPLE_W-1:0] sample_d;

  tick_divider #(.DIV(SLOW_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .slow  (slow_sel),
    .fire  (fire)
  );

  phase_accum #(.PHASE_W(PHASE_W), .STEP_W(FREQ_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fire),
    .step    (freq_word),
    .phase   (phase_q)
  );

  sine_halfwave_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .idx (phase_q[IDX_W-1:0]),
    .mag (mag)
  );

  assign pos_val  = {1'b0, mag};
  assign sample_d = phase_q[PHASE_W-1] ? (~pos_val + SAMPLE_W'(1)) : pos_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= fire;
      if (fire) sample <= sample_d;
    end
  end

endmodule

// File: rtl/sine_phase_gen_checker.sv
module sine_phase_gen_checker #(
  parameter int PHASE_W  = 8,
  parameter int FREQ_W   = 4,
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                slow_sel,
  input logic [FREQ_W-1:0]   freq_word,
  input logic [SAMPLE_W-1:0] sample,
  input logic                sample_valid,
  input logic [PHASE_W-1:0]  phase
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> phase == PHASE_W'($past(phase) + PHASE_W'($past(freq_word)))); // R1

  AST_NEG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(phase[PHASE_W-1])) |-> (sample[SAMPLE_W-1] || sample == '0)); // R3

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    sample != MOST_NEG); // R3

  AST_FAST_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !slow_sel) |=> sample_valid); // R5

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(tick)); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample)); // R7

  AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(freq_word) == '0) |-> $stable(phase)); // R9

endmodule

bind sine_phase_gen sine_phase_gen_checker #(
  .PHASE_W(PHASE_W), .FREQ_W(FREQ_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .slow_sel     (slow_sel),
  .freq_word    (freq_word),
  .sample       (sample),
  .sample_valid (sample_valid),
  .phase        (phase_q)
);

// File: tb/test_sine_phase_gen.sv
`timescale 1ns/1ps
module test_sine_phase_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] freq_word = '0;
  logic       slow_sel = 1'b0;
  logic [7:0] sample;
  logic       sample_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ph     = 0;

  always #4 clk = ~clk;

  sine_phase_gen i_sine_phase_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .freq_word    (freq_word),
    .slow_sel     (slow_sel),
    .sample       (sample),
    .sample_valid (sample_valid)
  );

  typedef struct packed { logic [3:0] fw; logic [15:0] n; } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{fw: 4'd1,  n: 16'd300},
    '{fw: 4'd15, n: 16'd40},
    '{fw: 4'd8,  n: 16'd64},
    '{fw: 4'd0,  n: 16'd6},
    '{fw: 4'd3,  n: 16'd100},
    '{fw: 4'd7,  n: 16'd80}
  };

  function automatic logic [7:0] expect_sample(input int p);
    int  m;
    real a;
    a = 127.0 * $sin(3.14159265358979323846 * real'(p % 128) / 128.0);
    m = int'(a);
    if (p >= 128) m = -m;
    return 8'(m);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // One tick; returns after the edge that registers any result.
  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  // Fast-mode sample: check value, strobe and one-cycle strobe width.
  task automatic fast_sample(input logic [3:0] fw, input string req);
    logic [7:0] held;
    freq_word = fw;
    pulse_tick();
    check({req, " valid"}, {7'd0, sample_valid}, 8'd1);
    check(req, sample, expect_sample(ph));
    held = sample;
    ph = (ph + fw) % 256;
    @(negedge clk);
    check("R7 strobe width", {7'd0, sample_valid}, 8'd0);
    check("R7 hold", sample, held);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    tick = 1'b0;
    @(negedge clk);
    check("R8 sample in reset", sample, 8'd0);
    check("R8 valid in reset", {7'd0, sample_valid}, 8'd0);
    @(negedge clk) rst_n = 1'b1;
    ph = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R8 idle after reset", {7'd0, sample_valid}, 8'd0);

    // Table walk: R1 R2 R3 R4 R5 R9 across patterns
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        fast_sample(VECS[v].fw, (VECS[v].fw == 0) ? "R9 frozen" :
                                 (ph >= 128) ? "R3 negated" : "R2 direct");
      end
    end

    // R8 first sample after reset reads entry 0; R4 exact peaks
    do_reset();
    fast_sample(4'd8, "R8 first sample");
    for (int i = 0; i < 7; i++) fast_sample(4'd8, "R1 step");
    freq_word = 4'd8;
    pulse_tick();
    check("R4 peak +127", sample, 8'h7F);
    ph = 72;
    for (int i = 0; i < 15; i++) fast_sample(4'd8, "R1 step");
    freq_word = 4'd8;
    pulse_tick();
    check("R4 peak -127", sample, 8'h81);
    ph = 200;
    // seam and wrap with step 1
    do_reset();
    for (int i = 0; i < 260; i++) fast_sample(4'd1, "R3 seam/wrap");

    // R6 slow mode: ticks 1..99 produce nothing, tick 100 fires
    do_reset();
    slow_sel = 1'b1;
    freq_word = 4'd5;
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 99; i++) begin
        pulse_tick();
        check("R6 no sample before 100th tick", {7'd0, sample_valid}, 8'd0);
      end
      pulse_tick();
      check("R6 100th tick valid", {7'd0, sample_valid}, 8'd1);
      check("R6 slow sample", sample, expect_sample(ph));
      ph = (ph + 5) % 256;
    end
    // restart: 30 slow ticks, drop slow, immediate sample, then full 100 again
    for (int i = 0; i < 30; i++) pulse_tick();
    check("R6 mid-count silent", {7'd0, sample_valid}, 8'd0);
    slow_sel = 1'b0;
    fast_sample(4'd5, "R6 fast after slow");
    slow_sel = 1'b1;
    for (int i = 0; i < 99; i++) begin
      pulse_tick();
      check("R6 count restarted", {7'd0, sample_valid}, 8'd0);
    end
    pulse_tick();
    check("R6 fires after restart", {7'd0, sample_valid}, 8'd1);
    check("R6 sample after restart", sample, expect_sample(ph));
    slow_sel = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule